// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate with Selectable Rounding

This block is the arithmetic heart of a signal-processing datapath. It multiplies two signed fractional operands, each with the radix point just after the sign bit (values from -1 up to just under +1). It then loads, adds or subtracts the full-precision product into a wide accumulator. The accumulator holds guard bits above the fraction field, so a run of additions may pass beyond ±1 for a while without losing anything. One operation is accepted per clock whenever the valid strobe is high.

A stored-word view of the accumulator is always present at the output. The accumulator is cut to operand width, rounded by one of three selectable rules, and clamped to the largest positive or negative word when the rounded value does not fit. An overflow flag reports clamping and stays set until the accumulator is cleared.

The raw accumulator is also brought out for code that saves the full-precision value. With the default 24-bit operands, the product is 48 bits and the accumulator is 56 bits, which leaves 8 guard bits.

Top module: `fxp_mac`

## Requirements
- R1: After a synchronous active-low reset, the accumulator, the stored word and the overflow flag are all zero.
- R2: A valid load (op code 01) replaces the accumulator with twice the signed product of the operands. The product is aligned so that the fraction field occupies accumulator bits 2*DATA_W-1..0 and the guard bits are sign-extended above it.
- R3: A valid multiply-add (op 10) adds the aligned product to the accumulator, and a valid multiply-subtract (op 11) subtracts it. The result appears one clock later, one operation is taken per cycle, and the sum wraps modulo 2 to the accumulator width.
- R4: A valid clear (op 00) sets the accumulator to zero and lowers the overflow flag.
- R5: While the valid strobe is low, the accumulator and the overflow flag keep their values whatever the op code and operands are.
- R6: The stored word keeps the accumulator bits from DATA_W upward. Rounding mode 00 (and the spare code 11) truncates, which rounds toward minus infinity.
- R7: Rounding mode 01 adds one to the kept part when the discarded part is one half or more, and otherwise leaves it unchanged.
- R8: Rounding mode 10 rounds above one half up and below one half down. At exactly one half it adds one only when the kept part is odd, so the kept LSB ends up zero.
- R9: When the rounded value lies outside the word range, the stored word is 2^(DATA_W-1)-1 for a positive accumulator and -2^(DATA_W-1) for a negative one. With 24-bit words these are 0x7FFFFF and 0x800000.
- R10: The overflow flag is high while the current stored word is clamped. It stays high after any clamped cycle until a valid clear.
- R11: Because of the guard bits, an accumulation that passes beyond ±1 and then returns into range ends with the exact value that an unbounded sum would give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Perform the selected operation this cycle |
| op_sel | input | 2 | 00 clear, 01 load, 10 multiply-add, 11 multiply-subtract |
| rnd_sel | input | 2 | 00 truncate, 01 half-up, 10 convergent, 11 truncate |
| opnd_a | input | DATA_W | Signed fractional multiplicand |
| opnd_b | input | DATA_W | Signed fractional multiplier |
| acc_out | output | 2*DATA_W+GUARD_W | Raw accumulator |
| word_out | output | DATA_W | Rounded and saturated stored word |
| ovf_out | output | 1 | Sticky saturation flag |

## Verification
The bench uses an 8-bit operand and 4-guard-bit configuration. It loads every pair of operands, which covers both extreme corners, including -1 times -1 producing +1. It also reads the stored word under all four rounding codes after each load. That sweep separates the three rounding rules at every possible remainder, since ties, values just above a tie and values just below it all occur.

Named tie values at positive and negative kept parts pin down the odd/even choice of the convergent rule. A run that climbs past +1 and comes back shows the guard bits at work, and a longer run shows the wrap at the accumulator width. A random mix of operations, idle cycles and mode changes then checks the sticky flag and the hold behaviour against a model built from integer arithmetic.

// File: rtl/mac_pkg.sv
// Shared encodings for the fixed-point multiply-accumulate block.
// Assumes 2-bit operation and rounding selects on the top-level ports.
package mac_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR = 2'b00,
        OP_LOAD  = 2'b01,
        OP_MAC   = 2'b10,
        OP_MSU   = 2'b11
    } mac_op_e;

    typedef enum logic [1:0] {
        RND_TRUNC   = 2'b00,
        RND_NEAREST = 2'b01,
        RND_CONV    = 2'b10,
        RND_SPARE   = 2'b11
    } rnd_mode_e;
endpackage

// File: rtl/mac_mult.sv
// Signed fractional multiplier.
// Forms the full 2*DATA_W product, sign-extends it to the accumulator
// width and shifts it left by one so the redundant sign bit disappears
// and the fraction field lines up at bit 2*DATA_W-1.
// Assumes ACC_W >= 2*DATA_W+1 so that -1 * -1 = +1 stays representable.
module mac_mult #(
    parameter int DATA_W = 24,
    parameter int ACC_W  = 56
) (
    input  logic [DATA_W-1:0] mul_a,
    input  logic [DATA_W-1:0] mul_b,
    output logic [ACC_W-1:0]  prod_aligned
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod_raw;
    logic        [ACC_W-1:0]  prod_ext;

    // full-precision signed product
    always_comb prod_raw = $signed(mul_a) * $signed(mul_b);

    // sign-extend then drop the duplicated sign bit
    always_comb begin
        prod_ext     = {{EXT_W{prod_raw[PROD_W-1]}}, prod_raw};
        prod_aligned = {prod_ext[ACC_W-2:0], 1'b0};
    end
endmodule

// File: rtl/mac_accum.sv
// Guard-bit accumulator register with the sticky overflow flag.
// Performs clear, load, add or subtract of the aligned product on a
// valid cycle and holds otherwise. The flag latches any cycle in which
// the stored-word stage reports clamping and drops only on a valid clear.
// Assumes sat_now is combinational from the current accumulator.
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  mac_op_e          op,
    input  logic [ACC_W-1:0] prod,
    input  logic             sat_now,
    output logic [ACC_W-1:0] acc,
    output logic             ovf_q
);
    logic is_clear;

    // a clear only counts when strobed
    always_comb is_clear = valid && (op == OP_CLEAR);

    // accumulator update, wrapping at ACC_W bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (valid) begin
            case (op)
                OP_CLEAR: acc <= '0;
                OP_LOAD:  acc <= prod;
                OP_MAC:   acc <= acc + prod;
                OP_MSU:   acc <= acc - prod;
                default:  acc <= acc;
            endcase
        end
    end

    // sticky saturation record
    always_ff @(posedge clk) begin
        if (!rst_n)        ovf_q <= 1'b0;
        else if (is_clear) ovf_q <= 1'b0;
        else if (sat_now)  ovf_q <= 1'b1;
    end

    p_clear_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_CLEAR) |=> (acc == '0 && !ovf_q));
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(acc));
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_LOAD) |=> acc == $past(prod));
    p_mac_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_MAC) |=> acc == ACC_W'($past(acc) + $past(prod)));
    p_msu_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_MSU) |=> acc == ACC_W'($past(acc) - $past(prod)));
    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !is_clear) |=> ovf_q);
endmodule

// File: rtl/mac_round_sat.sv
// Stored-word stage: rounds the accumulator at bit DATA_W and clamps it.
// The kept part is the accumulator from bit DATA_W upward; the discarded
// part is the low DATA_W bits. After rounding, the value fits the word
// when every guard bit and the word sign bit agree with the top bit.
// Assumes DATA_W >= 2 and a purely combinational use.
module mac_round_sat
    import mac_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int GUARD_W = 8
) (
    input  logic [2*DATA_W+GUARD_W-1:0] acc,
    input  rnd_mode_e                   mode,
    output logic [DATA_W-1:0]           word,
    output logic                        sat
);
    localparam int ACC_W = 2 * DATA_W + GUARD_W;
    localparam int KEEP_W = ACC_W - DATA_W;
    localparam int CHK_W = KEEP_W - DATA_W + 2;
    localparam logic [DATA_W-1:0] WORD_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] WORD_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    logic [KEEP_W-1:0] kept;
    logic [DATA_W-1:0] frac_low;
    logic              tie_bit;
    logic              below_tie_zero;
    logic              bump;
    logic [KEEP_W:0]   rounded;
    logic [CHK_W-1:0]  agree;
    logic              fits;

    // split the accumulator at the rounding point
    always_comb begin
        kept           = acc[ACC_W-1:DATA_W];
        frac_low       = acc[DATA_W-1:0];
        tie_bit        = frac_low[DATA_W-1];
        below_tie_zero = (frac_low[DATA_W-2:0] == '0);
    end

    // rounding increment chosen by mode
    always_comb begin
        case (mode)
            RND_NEAREST: bump = tie_bit;
            RND_CONV:    bump = tie_bit && (!below_tie_zero || kept[0]);
            default:     bump = 1'b0;
        endcase
    end

    // apply the increment one bit wider so it cannot wrap
    always_comb rounded = {kept[KEEP_W-1], kept} + {{KEEP_W{1'b0}}, bump};

    // guard bits and word sign must all match the top bit
    for (genvar g = 0; g < CHK_W; g++) begin : g_agree
        assign agree[g] = (rounded[DATA_W-1+g] == rounded[KEEP_W]);
    end

    // clamp or pass the low word
    always_comb begin
        fits = &agree;
        sat  = !fits;
        if (fits)                 word = rounded[DATA_W-1:0];
        else if (rounded[KEEP_W]) word = WORD_MIN;
        else                      word = WORD_MAX;
    end

    // p_sat_extreme_r9: a clamped word is the extreme matching the accumulator sign
    always_comb begin
        p_sat_extreme_r9: assert (!sat || word == (acc[ACC_W-1] ? WORD_MIN : WORD_MAX));
    end
endmodule

// File: rtl/fxp_mac.sv
// Top of the fixed-point multiply-accumulate block.
// Joins the multiplier, the accumulator and the stored-word stage. The
// overflow output shows both the recorded flag and clamping of the word
// currently presented. Assumes operands are fractional with the radix
// point just after the sign bit.
module fxp_mac
    import mac_pkg::*;
#(
    parameter int DATA_W  = 24,
    parameter int GUARD_W = 8,
    localparam int ACC_W  = 2 * DATA_W + GUARD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        rnd_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [ACC_W-1:0]  acc_out,
    output logic [DATA_W-1:0] word_out,
    output logic              ovf_out
);
    logic [ACC_W-1:0] prod_aligned;
    logic [ACC_W-1:0] acc_q;
    logic             sat_now;
    logic             ovf_q;
    mac_op_e          op_e;
    rnd_mode_e        rnd_e;

    // map raw select pins onto the shared encodings
    always_comb begin
        op_e  = mac_op_e'(op_sel);
        rnd_e = rnd_mode_e'(rnd_sel);
    end

    mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mult (
        .mul_a        (opnd_a),
        .mul_b        (opnd_b),
        .prod_aligned (prod_aligned)
    );

    mac_accum #(.ACC_W(ACC_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (in_valid),
        .op      (op_e),
        .prod    (prod_aligned),
        .sat_now (sat_now),
        .acc     (acc_q),
        .ovf_q   (ovf_q)
    );

    mac_round_sat #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_round (
        .acc  (acc_q),
        .mode (rnd_e),
        .word (word_out),
        .sat  (sat_now)
    );

    // drive the outputs
    always_comb begin
        acc_out = acc_q;
        ovf_out = ovf_q | sat_now;
    end

    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (acc_out == '0 && word_out == '0 && !ovf_out));
endmodule

// File: tb/tb_fxp_mac.sv
module tb_fxp_mac;
    localparam int  DW = 8;
    localparam int  GW = 4;
    localparam int  AW = 2 * DW + GW;
    localparam time CLK_PERIOD = 10;
    localparam int  MAX_CYCLES = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op_sel = 2'b00;
    logic [1:0]    rnd_sel = 2'b00;
    logic [DW-1:0] opnd_a = '0;
    logic [DW-1:0] opnd_b = '0;
    logic [AW-1:0] acc_out;
    logic [DW-1:0] word_out;
    logic          ovf_out;

    int     n_checks = 0;
    int     n_fails  = 0;
    bit     finished = 1'b0;
    longint m_acc = 0;
    bit     m_ovf = 1'b0;
    int unsigned seed = 32'h1234_5678;

    fxp_mac #(.DATA_W(DW), .GUARD_W(GW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .rnd_sel(rnd_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_out(acc_out), .word_out(word_out), .ovf_out(ovf_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint sx(longint v, int w);
        return (v <<< (64 - w)) >>> (64 - w);
    endfunction

    // expected stored word and clamp from the requirement arithmetic
    function automatic longint exp_word(longint acc, int mode, output bit sat);
        longint q, rem, half, maxv, minv;
        q    = acc >>> DW;
        rem  = acc & ((longint'(1) << DW) - 1);
        half = longint'(1) << (DW - 1);
        if (mode == 1 && rem >= half) q = q + 1;
        if (mode == 2 && (rem > half || (rem == half && (q & 1) != 0))) q = q + 1;
        maxv = half - 1;
        minv = -half;
        sat  = (q > maxv) || (q < minv);
        if (q > maxv) q = maxv;
        if (q < minv) q = minv;
        return q;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            if (n_fails < 40)
                $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_outputs(string req);
        bit s;
        longint w;
        w = exp_word(m_acc, int'(rnd_sel), s);
        chk(sx(longint'(acc_out), AW) == m_acc, req, "acc", sx(longint'(acc_out), AW), m_acc);
        chk(sx(longint'(word_out), DW) == w, s ? "R9" : req, "word", sx(longint'(word_out), DW), w);
        chk(ovf_out == (m_ovf | s), "R10", "ovf", longint'(ovf_out), longint'(m_ovf | s));
    endtask

    // one clocked operation with the model advanced at the same edge
    task automatic step(bit v, logic [1:0] op, logic [DW-1:0] a, logic [DW-1:0] b);
        bit s;
        longint p, w;
        @(negedge clk);
        in_valid = v; op_sel = op; opnd_a = a; opnd_b = b;
        w = exp_word(m_acc, int'(rnd_sel), s);
        if (v && op == 2'b00) m_ovf = 1'b0;
        else if (s)           m_ovf = 1'b1;
        p = 2 * sx(longint'(a), DW) * sx(longint'(b), DW);
        if (v) begin
            case (op)
                2'b00: m_acc = 0;
                2'b01: m_acc = sx(p, AW);
                2'b10: m_acc = sx(m_acc + p, AW);
                default: m_acc = sx(m_acc - p, AW);
            endcase
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        if (w == 12345) $display("unused");
    endtask

    task automatic sweep_modes();
        for (int m = 0; m < 4; m++) begin
            rnd_sel = 2'(m);
            #1;
            case (m)
                1: check_outputs("R7");
                2: check_outputs("R8");
                default: check_outputs("R6");
            endcase
        end
    endtask

    task automatic tie_check(logic [DW-1:0] a, logic [DW-1:0] b,
                             int e_tr, int e_nr, int e_cv);
        step(1'b1, 2'b01, a, b);
        rnd_sel = 2'b00; #1;
        chk(sx(longint'(word_out), DW) == e_tr, "R6", "tie trunc", sx(longint'(word_out), DW), e_tr);
        rnd_sel = 2'b01; #1;
        chk(sx(longint'(word_out), DW) == e_nr, "R7", "tie nearest", sx(longint'(word_out), DW), e_nr);
        rnd_sel = 2'b10; #1;
        chk(sx(longint'(word_out), DW) == e_cv, "R8", "tie convergent", sx(longint'(word_out), DW), e_cv);
    endtask

    function automatic int unsigned rnd_next(int unsigned x);
        x ^= x << 13; x ^= x >> 17; x ^= x << 5;
        return x;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    endtask

    // watchdog
    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk(acc_out == '0, "R1", "acc after reset", longint'(acc_out), 0);
        chk(word_out == '0, "R1", "word after reset", longint'(word_out), 0);
        chk(ovf_out == 1'b0, "R1", "ovf after reset", longint'(ovf_out), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 with R6-R9: every operand pair loaded, every mode read
        for (int ia = 0; ia < (1 << DW); ia++) begin
            for (int ib = 0; ib < (1 << DW); ib++) begin
                step(1'b1, 2'b01, DW'(ia), DW'(ib));
                check_outputs("R2");
                sweep_modes();
            end
        end

        // R4: clear drops the flag set by the -1 * -1 corner
        step(1'b1, 2'b01, 8'h80, 8'h80);
        check_outputs("R9");
        step(1'b1, 2'b00, 8'h00, 8'h00);
        chk(ovf_out == 1'b0 && acc_out == '0, "R4", "clear", longint'(ovf_out), 0);

        // named ties: half exactly, odd and even kept parts, both signs
        tie_check(8'h01, 8'h40, 0, 1, 0);
        tie_check(8'h03, 8'h40, 1, 2, 2);
        tie_check(8'hFF, 8'h40, -1, 0, 0);
        tie_check(8'hFD, 8'h40, -2, -1, -2);
        tie_check(8'h01, 8'h41, 0, 1, 1);
        tie_check(8'h01, 8'h3F, 0, 0, 0);

        // R11: climb past +1 then return exactly
        rnd_sel = 2'b01;
        step(1'b1, 2'b00, 8'h00, 8'h00);
        step(1'b1, 2'b01, 8'h20, 8'h40);
        for (int k = 0; k < 10; k++) step(1'b1, 2'b10, 8'h7F, 8'h7F);
        check_outputs("R9");
        for (int k = 0; k < 10; k++) step(1'b1, 2'b11, 8'h7F, 8'h7F);
        chk(sx(longint'(word_out), DW) == 16, "R11", "exact after excursion",
            sx(longint'(word_out), DW), 16);
        chk(ovf_out == 1'b1, "R10", "flag kept after return", longint'(ovf_out), 1);

        // R3: wrap at the accumulator width
        step(1'b1, 2'b00, 8'h00, 8'h00);
        for (int k = 0; k < 20; k++) begin
            step(1'b1, 2'b10, 8'h7F, 8'h7F);
            check_outputs("R3");
        end

        // R5: idle cycles ignore op and operands, including clear
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 2'(k), 8'h7F, 8'h80);
            check_outputs("R5");
        end

        // random mix of operations, idle cycles and modes
        for (int k = 0; k < 4000; k++) begin
            seed = rnd_next(seed);
            rnd_sel = seed[1:0];
            step(seed[4:2] != 3'b000,
                 (seed[9:5] == 5'd0) ? 2'b00 : ((seed[10]) ? 2'b10 : {1'b1, seed[11]}),
                 seed[19:12], seed[27:20]);
            check_outputs(seed[4:2] == 3'b000 ? "R5" : "R3");
        end

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule